// File: doc/BRIEF.md
# Two-Line Interrupt Controller Register Bank

This block is the software-facing register bank of an interrupt controller that serves 51 sources. A separate trigger-capture block turns the source pins into a raw pending vector; this bank reads that vector, masks it with a per-source enable, and steers each enabled pending source onto one of two outputs. A per-source select bit routes the source to the fast interrupt line when set, or to the normal line when clear. The bank sends the capture block the event-type, sensitivity and dual-edge configuration. It also sends a one-cycle clear pulse for edge-type pending bits.

Every 51-bit quantity appears on the 32-bit register bus as a pair of words. The low word carries sources 0 to 31. The high word, selected by address bit 2, carries sources 32 to 50 in its bits 18:0. The lowest 128 bytes of the address space are an old register window. It is decoded so that it answers harmlessly, but it holds nothing. Enable and edge-pending state are changed through separate set and clear addresses, so software never needs a read-modify-write sequence.

Top module: `intc_regbank`

## Requirements
- R1: Each register is a low/high word pair; address bit 2 set picks the high word, which returns sources 50:32 in bits 18:0 with bits 31:19 read as zero, and a high-word write uses only wdata bits 18:0.
- R2: Any address below 0x80 reads as zero, and a write there leaves select, enable and event type unchanged.
- R3: Address 0x80/0x84 reads raw AND enable AND NOT select, 0x88/0x8C reads raw AND enable AND select, and 0x90/0x94 reads the raw pending input.
- R4: A write to 0x98 (low) or 0x9C (high) replaces only that half of the select mask, and the mask reads back at the same addresses.
- R5: A write to 0xA0/0xA4 sets every enable bit whose written bit is one; a write to 0xA8/0xAC clears every enable bit whose written bit is one; 0xA0/0xA4 read the enable mask.
- R6: The event type at 0xD0/0xD4 changes only on a high-word write, and then only in sources 50:47 (wdata bits 18:15); a low-word write is ignored.
- R7: A write to 0xD8/0xDC drives edge_clr, for exactly the cycle after the write, with the written bits restricted to sources whose sensitivity bit is zero (edge type); 0xE0/0xE4 reads raw AND NOT sensitivity.
- R8: Sensitivity (0xC0/0xC4) and dual-edge (0xC8/0xCC) read their configured constants and ignore writes; 0xA8, 0xB8 and 0xD8 and any unlisted address read as zero, and writes to unlisted addresses change nothing.
- R9: irq_o and fiq_o are registered ORs of the normal and fast status vectors, so they follow a raw pending change after one clock edge and a register write after two.
- R10: After reset, select, enable and the software-trigger register are zero, the event type holds its reset constant, both interrupt outputs and edge_clr are low; 0xB0 reads the software-trigger register and writes to 0xB0 and 0xB8 change nothing.
- R11: bus_rdata carries the data of a read in the cycle after the access and is zero after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | Access is a write when high |
| bus_addr | input | 17 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| raw_pend | input | 51 | Raw pending vector from the capture block |
| sense_cfg | output | 51 | Sensitivity per source, 1 = level |
| dual_cfg | output | 51 | Dual-edge enable per source |
| event_type | output | 51 | Polarity per source, 1 = high/rising |
| edge_clr | output | 51 | One-cycle clear of edge pending bits |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
A read is due one clock edge after the access, a register write shows in readback from the next access, edge_clr appears one edge after its write, and the interrupt lines need one edge after a raw pending change and two after a register write. The bench drives every input on the falling edge and samples on the falling edge that follows the edge under test. It checks the lines both before and after the expected edge, so a missing or extra register stage is caught. The outputs after a write are also checked one falling edge later.

// File: rtl/intc_pkg.sv
// Shared constants, register identifiers and word helpers for the
// interrupt controller register bank. Assumes SRC_N lies between WORD_W+1
// and 2*WORD_W.
package intc_pkg;
    localparam int SRC_N    = 51;
    localparam int WORD_W   = 32;
    localparam int HI_W     = SRC_N - WORD_W;
    localparam int ADDR_W   = 17;
    localparam int EVT_WR_N = 4;

    // Offsets inside the new window, high-word bit removed
    localparam int OFS_IRQ_ST   = 'h00;
    localparam int OFS_FIQ_ST   = 'h08;
    localparam int OFS_RAW      = 'h10;
    localparam int OFS_SEL      = 'h18;
    localparam int OFS_EN_SET   = 'h20;
    localparam int OFS_EN_CLR   = 'h28;
    localparam int OFS_SWT      = 'h30;
    localparam int OFS_SWT_CLR  = 'h38;
    localparam int OFS_SENSE    = 'h40;
    localparam int OFS_DUAL     = 'h48;
    localparam int OFS_EVT      = 'h50;
    localparam int OFS_EDGE_CLR = 'h58;
    localparam int OFS_EDGE_ST  = 'h60;

    typedef logic [SRC_N-1:0] src_vec_t;

    typedef enum logic [3:0] {
        RG_NONE, RG_IRQ_ST, RG_FIQ_ST, RG_RAW, RG_SEL, RG_EN_SET,
        RG_EN_CLR, RG_SWT, RG_SWT_CLR, RG_SENSE, RG_DUAL, RG_EVT,
        RG_EDGE_CLR, RG_EDGE_ST
    } reg_id_e;

    // Move a bus word to its source positions
    function automatic src_vec_t place_word(input logic hi, input logic [WORD_W-1:0] d);
        src_vec_t v;
        v = '0;
        if (hi) v[SRC_N-1:WORD_W] = d[HI_W-1:0];
        else    v[WORD_W-1:0]     = d;
        return v;
    endfunction

    // Extract the addressed half of a source vector as a bus word
    function automatic logic [WORD_W-1:0] pick_word(input logic hi, input src_vec_t v);
        logic [WORD_W-1:0] w;
        w = '0;
        if (hi) w[HI_W-1:0] = v[SRC_N-1:WORD_W];
        else    w           = v[WORD_W-1:0];
        return w;
    endfunction
endpackage

// File: rtl/intc_addr_dec.sv
// Address decoder: maps a bus address to a register identifier and a
// high-word flag. Addresses below NEW_BASE, misaligned and unlisted
// offsets all decode to RG_NONE.
module intc_addr_dec
    import intc_pkg::*;
#(
    parameter int AW       = ADDR_W,
    parameter int NEW_BASE = 'h80
) (
    input  logic [AW-1:0] addr,
    output reg_id_e       id,
    output logic          hi
);
    logic [AW-1:0] rel;
    logic [AW-1:0] key;

    // Strip the window base and the half-select bit, then match offsets
    always_comb begin
        rel = addr - AW'(NEW_BASE);
        hi  = rel[2];
        key = rel & ~AW'(4);
        id  = RG_NONE;
        if (addr >= AW'(NEW_BASE)) begin
            case (key)
                AW'(OFS_IRQ_ST):   id = RG_IRQ_ST;
                AW'(OFS_FIQ_ST):   id = RG_FIQ_ST;
                AW'(OFS_RAW):      id = RG_RAW;
                AW'(OFS_SEL):      id = RG_SEL;
                AW'(OFS_EN_SET):   id = RG_EN_SET;
                AW'(OFS_EN_CLR):   id = RG_EN_CLR;
                AW'(OFS_SWT):      id = RG_SWT;
                AW'(OFS_SWT_CLR):  id = RG_SWT_CLR;
                AW'(OFS_SENSE):    id = RG_SENSE;
                AW'(OFS_DUAL):     id = RG_DUAL;
                AW'(OFS_EVT):      id = RG_EVT;
                AW'(OFS_EDGE_CLR): id = RG_EDGE_CLR;
                AW'(OFS_EDGE_ST):  id = RG_EDGE_ST;
                default:           id = RG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/intc_cfg_regs.sv
// Writable per-source state: select mask, enable mask, software-trigger
// register and event type. Assumes wr_en is already qualified by a valid
// write access and that id/hi come from the address decoder.
module intc_cfg_regs
    import intc_pkg::*;
#(
    parameter src_vec_t EVT_RST = 51'h5F07FFF8FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_id_e           id,
    input  logic              hi,
    input  logic [WORD_W-1:0] wdata,
    output src_vec_t          sel_q,
    output src_vec_t          en_q,
    output src_vec_t          swt_q,
    output src_vec_t          evt_q
);
    localparam src_vec_t EVT_WMASK = {{EVT_WR_N{1'b1}}, {(SRC_N-EVT_WR_N){1'b0}}};

    src_vec_t wvec;
    assign wvec = place_word(hi, wdata);

    // Select: overwrite only the addressed half
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (wr_en && id == RG_SEL) begin
            if (hi) sel_q <= {wvec[SRC_N-1:WORD_W], sel_q[WORD_W-1:0]};
            else    sel_q <= {sel_q[SRC_N-1:WORD_W], wvec[WORD_W-1:0]};
        end
    end

    // Enable: separate set and clear addresses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en && id == RG_EN_SET) begin
            en_q <= en_q | wvec;
        end else if (wr_en && id == RG_EN_CLR) begin
            en_q <= en_q & ~wvec;
        end
    end

    // Software trigger: cleared by reset, not changed by the bus
    always_ff @(posedge clk) begin
        if (!rst_n) swt_q <= '0;
    end

    // Event type: only the top EVT_WR_N sources, only via the high word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= EVT_RST;
        end else if (wr_en && id == RG_EVT && hi) begin
            evt_q <= (evt_q & ~EVT_WMASK) | (wvec & EVT_WMASK);
        end
    end
endmodule

// File: rtl/intc_out_gen.sv
// Output stage: one registered line per route. Route 0 takes sources
// whose select bit is clear (normal line), route 1 those whose select bit
// is set (fast line). Assumes raw and masks are stable at the clock edge.
module intc_out_gen
    import intc_pkg::*;
#(
    parameter int N_ROUTE = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  src_vec_t           raw,
    input  src_vec_t           en,
    input  src_vec_t           sel,
    output logic [N_ROUTE-1:0] line_q
);
    for (genvar g = 0; g < N_ROUTE; g++) begin : g_route
        src_vec_t route_mask;
        assign route_mask = (g == 0) ? ~sel : sel;

        // Register the OR of pending, enabled sources on this route
        always_ff @(posedge clk) begin
            if (!rst_n) line_q[g] <= 1'b0;
            else        line_q[g] <= |(raw & en & route_mask);
        end
    end
endmodule

// File: rtl/intc_regbank.sv
// Top of the interrupt controller register bank. Decodes the 32-bit
// register bus, holds per-source configuration, builds the status views,
// registers read data and the edge clear pulse, and drives the two
// interrupt lines. Assumes single-cycle accesses and a raw pending vector
// supplied synchronously by the trigger-capture block.
module intc_regbank
    import intc_pkg::*;
#(
    parameter int       NEW_BASE  = 'h80,
    parameter src_vec_t SENSE_RST = 51'h1F07FFF8FFFF,
    parameter src_vec_t DUAL_RST  = 51'h00F800070000,
    parameter src_vec_t EVT_RST   = 51'h5F07FFF8FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [SRC_N-1:0]  raw_pend,
    output logic [SRC_N-1:0]  sense_cfg,
    output logic [SRC_N-1:0]  dual_cfg,
    output logic [SRC_N-1:0]  event_type,
    output logic [SRC_N-1:0]  edge_clr,
    output logic              irq_o,
    output logic              fiq_o
);
    reg_id_e           id;
    logic              hi;
    logic              wr_acc;
    logic              rd_acc;
    src_vec_t          sel_q;
    src_vec_t          en_q;
    src_vec_t          swt_q;
    src_vec_t          evt_q;
    src_vec_t          rd_vec;
    src_vec_t          wvec;
    logic [WORD_W-1:0] rd_word;
    logic [1:0]        lines;

    assign wr_acc = bus_valid && bus_write;
    assign rd_acc = bus_valid && !bus_write;
    assign wvec   = place_word(hi, bus_wdata);

    intc_addr_dec #(.AW(ADDR_W), .NEW_BASE(NEW_BASE)) u_dec (
        .addr (bus_addr),
        .id   (id),
        .hi   (hi)
    );

    intc_cfg_regs #(.EVT_RST(EVT_RST)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_acc),
        .id    (id),
        .hi    (hi),
        .wdata (bus_wdata),
        .sel_q (sel_q),
        .en_q  (en_q),
        .swt_q (swt_q),
        .evt_q (evt_q)
    );

    intc_out_gen #(.N_ROUTE(2)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (raw_pend),
        .en     (en_q),
        .sel    (sel_q),
        .line_q (lines)
    );

    assign irq_o      = lines[0];
    assign fiq_o      = lines[1];
    assign sense_cfg  = SENSE_RST;
    assign dual_cfg   = DUAL_RST;
    assign event_type = evt_q;

    // Read multiplexer: pick the full-width view, then the addressed half
    always_comb begin
        case (id)
            RG_IRQ_ST:  rd_vec = raw_pend & en_q & ~sel_q;
            RG_FIQ_ST:  rd_vec = raw_pend & en_q & sel_q;
            RG_RAW:     rd_vec = raw_pend;
            RG_SEL:     rd_vec = sel_q;
            RG_EN_SET:  rd_vec = en_q;
            RG_SWT:     rd_vec = swt_q;
            RG_SENSE:   rd_vec = SENSE_RST;
            RG_DUAL:    rd_vec = DUAL_RST;
            RG_EVT:     rd_vec = evt_q;
            RG_EDGE_ST: rd_vec = raw_pend & ~SENSE_RST;
            default:    rd_vec = '0;
        endcase
        rd_word = pick_word(hi, rd_vec);
    end

    // Registered read data, zero after cycles without a read
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_acc) bus_rdata <= rd_word;
        else             bus_rdata <= '0;
    end

    // One-cycle clear pulse toward the capture block, edge sources only
    always_ff @(posedge clk) begin
        if (!rst_n)                           edge_clr <= '0;
        else if (wr_acc && id == RG_EDGE_CLR) edge_clr <= wvec & ~SENSE_RST;
        else                                  edge_clr <= '0;
    end
endmodule

// File: rtl/intc_regbank_chk.sv
// Property checker for intc_regbank, attached by the bind below. Observes
// bus ports, outputs and the enable/select/event registers.
module intc_regbank_chk
    import intc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_rdata,
    input logic [SRC_N-1:0]  raw_pend,
    input logic [SRC_N-1:0]  sense_cfg,
    input logic [SRC_N-1:0]  edge_clr,
    input logic [SRC_N-1:0]  en_q,
    input logic [SRC_N-1:0]  sel_q,
    input logic [SRC_N-1:0]  evt_q,
    input logic              irq_o,
    input logic              fiq_o
);
    // R2
    legacy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr < ADDR_W'('h80))
        |=> ($stable(en_q) && $stable(sel_q) && $stable(evt_q)));

    // R6
    event_low_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(evt_q[SRC_N-EVT_WR_N-1:0]));

    // R7
    edge_clr_level_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_clr & sense_cfg) == '0);

    // R8
    wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == ADDR_W'('hA8)) |=> bus_rdata == '0);

    // R9
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_o == $past(|(raw_pend & en_q & ~sel_q)));

    // R9
    fiq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> fiq_o == $past(|(raw_pend & en_q & sel_q)));

    // R11
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> bus_rdata == '0);
endmodule

bind intc_regbank intc_regbank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .raw_pend  (raw_pend),
    .sense_cfg (sense_cfg),
    .edge_clr  (edge_clr),
    .en_q      (en_q),
    .sel_q     (sel_q),
    .evt_q     (evt_q),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o)
);

// File: tb/intc_regbank_tb.sv
// Directed bench: one task per scenario, each checking its own results.
// Inputs change on the falling edge; outputs are sampled on falling edges.
module intc_regbank_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [16:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [50:0] raw_pend = '0;
    logic [50:0] sense_cfg, dual_cfg, event_type, edge_clr;
    logic        irq_o, fiq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intc_regbank u_dut (
        .clk (clk), .rst_n (rst_n), .bus_valid (bus_valid), .bus_write (bus_write),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .raw_pend (raw_pend), .sense_cfg (sense_cfg), .dual_cfg (dual_cfg),
        .event_type (event_type), .edge_clr (edge_clr), .irq_o (irq_o), .fiq_o (fiq_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [16:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_rd(input logic [16:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R10 irq after reset", irq_o, 0);
        chk("R10 fiq after reset", fiq_o, 0);
        chk("R10 edge_clr after reset", edge_clr, 0);
        chk("R11 rdata after reset", bus_rdata, 0);
        bus_rd(17'h0A0, d); chk("R10 enable low reset", d, 0);
        bus_rd(17'h0A4, d); chk("R10 enable high reset", d, 0);
        bus_rd(17'h098, d); chk("R10 select low reset", d, 0);
        bus_rd(17'h0D4, d); chk("R10 event high reset", d, 32'h5F07);
        bus_rd(17'h0D0, d); chk("R10 event low reset", d, 32'hFFF8FFFF);
        bus_rd(17'h0B0, d); chk("R10 trigger reset", d, 0);
    endtask

    task automatic t_legacy();
        logic [31:0] d;
        raw_pend = '1;
        bus_wr(17'h020, 32'hFFFFFFFF);
        bus_wr(17'h018, 32'hFFFFFFFF);
        bus_rd(17'h010, d); chk("R2 legacy read zero", d, 0);
        bus_rd(17'h07C, d); chk("R2 legacy top read zero", d, 0);
        bus_rd(17'h0A0, d); chk("R2 enable untouched", d, 0);
        bus_rd(17'h098, d); chk("R2 select untouched", d, 0);
        raw_pend = '0;
    endtask

    task automatic t_select();
        logic [31:0] d;
        bus_wr(17'h098, 32'hA5A5A5A5);
        bus_wr(17'h09C, 32'hFFFFFFFF);
        bus_rd(17'h098, d); chk("R4 select low", d, 32'hA5A5A5A5);
        bus_rd(17'h09C, d); chk("R1 select high 19 bits", d, 32'h0007FFFF);
        bus_wr(17'h098, 32'h0000000F);
        bus_rd(17'h09C, d); chk("R4 high kept on low write", d, 32'h0007FFFF);
        bus_rd(17'h098, d); chk("R4 low replaced", d, 32'h0000000F);
        bus_wr(17'h09C, 32'h0);
        bus_rd(17'h098, d); chk("R4 low kept on high write", d, 32'h0000000F);
        bus_wr(17'h098, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        bus_wr(17'h0A0, 32'h0000F0F0);
        bus_wr(17'h0A0, 32'h00000F00);
        bus_rd(17'h0A0, d); chk("R5 enable set accumulates", d, 32'h0000FFF0);
        bus_wr(17'h0A8, 32'h000000F0);
        bus_rd(17'h0A0, d); chk("R5 enable clear", d, 32'h0000FF00);
        bus_wr(17'h0A4, 32'hFFF40001);
        bus_rd(17'h0A4, d); chk("R1 enable high masked", d, 32'h00040001);
        bus_wr(17'h0AC, 32'h00000001);
        bus_rd(17'h0A4, d); chk("R5 enable high clear", d, 32'h00040000);
        bus_wr(17'h0A8, 32'hFFFFFFFF);
        bus_wr(17'h0AC, 32'hFFFFFFFF);
        bus_rd(17'h0A0, d); chk("R5 enable all cleared", d, 0);
    endtask

    task automatic t_status();
        logic [31:0] d;
        raw_pend = '1;
        bus_wr(17'h0A0, 32'h0000000F);
        bus_wr(17'h098, 32'h00000003);
        bus_wr(17'h0A4, 32'h00000010);
        bus_rd(17'h080, d); chk("R3 normal status low", d, 32'h0000000C);
        bus_rd(17'h088, d); chk("R3 fast status low", d, 32'h00000003);
        bus_rd(17'h084, d); chk("R3 normal status high", d, 32'h00000010);
        bus_rd(17'h08C, d); chk("R3 fast status high", d, 0);
        bus_rd(17'h090, d); chk("R3 raw low", d, 32'hFFFFFFFF);
        bus_rd(17'h094, d); chk("R3 raw high", d, 32'h0007FFFF);
        bus_rd(17'h0E0, d); chk("R7 edge status low", d, 32'h00070000);
        bus_rd(17'h0E4, d); chk("R7 edge status high", d, 32'h0007E0F8);
        raw_pend = '0;
        bus_wr(17'h0A8, 32'hFFFFFFFF);
        bus_wr(17'h0AC, 32'hFFFFFFFF);
        bus_wr(17'h098, 32'h0);
    endtask

    task automatic t_event();
        logic [31:0] d;
        bus_wr(17'h0D0, 32'h0);
        bus_rd(17'h0D0, d); chk("R6 low write ignored", d, 32'hFFF8FFFF);
        bus_wr(17'h0D4, 32'hFFFFFFFF);
        bus_rd(17'h0D4, d); chk("R6 high write top four", d, 32'h0007DF07);
        chk("R6 event_type port", event_type, 51'h7DF07FFF8FFFF);
        bus_wr(17'h0D4, 32'h0);
        bus_rd(17'h0D4, d); chk("R6 top four cleared", d, 32'h00005F07);
    endtask

    task automatic t_edge_clear();
        bus_wr(17'h0D8, 32'hFFFFFFFF);
        chk("R7 edge_clr low pulse", edge_clr, 51'h00000070000);
        @(negedge clk);
        chk("R7 edge_clr one cycle", edge_clr, 0);
        bus_wr(17'h0DC, 32'hFFFFFFFF);
        chk("R7 edge_clr high pulse", edge_clr, {19'h7E0F8, 32'h0});
        @(negedge clk);
        chk("R7 edge_clr high ends", edge_clr, 0);
    endtask

    task automatic t_ro_wo();
        logic [31:0] d;
        bus_wr(17'h0C0, 32'h0);
        bus_wr(17'h0CC, 32'hFFFFFFFF);
        bus_rd(17'h0C0, d); chk("R8 sense low", d, 32'hFFF8FFFF);
        bus_rd(17'h0C4, d); chk("R8 sense high", d, 32'h00001F07);
        bus_rd(17'h0C8, d); chk("R8 dual low", d, 32'h00070000);
        bus_rd(17'h0CC, d); chk("R8 dual high", d, 32'h000000F8);
        bus_wr(17'h0A0, 32'h00000055);
        bus_rd(17'h0A8, d); chk("R8 enable clear reads zero", d, 0);
        bus_rd(17'h0B8, d); chk("R8 trigger clear reads zero", d, 0);
        bus_rd(17'h0D8, d); chk("R8 edge clear reads zero", d, 0);
        bus_wr(17'h0F0, 32'hFFFFFFFF);
        bus_wr(17'h0A2, 32'hFFFFFFFF);
        bus_rd(17'h0F0, d); chk("R8 unknown reads zero", d, 0);
        bus_rd(17'h0A0, d); chk("R8 unknown write no effect", d, 32'h00000055);
        bus_wr(17'h0B0, 32'hFFFFFFFF);
        bus_wr(17'h0B8, 32'hFFFFFFFF);
        bus_rd(17'h0B0, d); chk("R10 trigger write ignored", d, 0);
        @(negedge clk);
        chk("R11 rdata zero when idle", bus_rdata, 0);
        bus_wr(17'h0A8, 32'hFFFFFFFF);
    endtask

    task automatic t_lines();
        bus_wr(17'h0A0, 32'h00000001);
        raw_pend = 51'h1;
        #1 chk("R9 irq not yet", irq_o, 0);
        @(negedge clk);
        chk("R9 irq one edge after raw", irq_o, 1);
        chk("R9 fiq stays low", fiq_o, 0);
        bus_wr(17'h098, 32'h00000001);
        chk("R9 irq holds one edge after write", irq_o, 1);
        @(negedge clk);
        chk("R9 irq drops after select", irq_o, 0);
        chk("R9 fiq rises after select", fiq_o, 1);
        bus_wr(17'h0A8, 32'h00000001);
        @(negedge clk);
        chk("R9 fiq drops after disable", fiq_o, 0);
        raw_pend = 51'h0;
        bus_wr(17'h098, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_legacy();
        t_select();
        t_enable();
        t_status();
        t_event();
        t_edge_clear();
        t_ro_wo();
        t_lines();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
        end
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule